// File: doc/BRIEF.md
# Seven-slot three-lane pixel serializer

This block turns one 21-bit parallel word per pixel clock period into three serial data lanes and a fourth lane that carries a framing clock pattern. Every pixel period is split into seven equal bit slots driven by a bit clock at seven times the pixel rate. The bit clock is supplied already phase-aligned: each pixel clock rising edge trails, by less than one bit period, the bit clock rising edge that opens slot 0. The line drivers that follow the block take the four single-bit lanes.

The word is captured on the falling pixel clock edge. It is moved in parallel into three seven-bit shift registers at the bit clock edge that opens the next slot 0, and shifted out most significant bit first. The framing lane repeats a fixed seven-slot pattern, high for four slots of each period, which a receiver uses to find word boundaries. An active-low shutdown clears every register, silences all four lanes and stops the framing lane. After release the block re-aligns its slot counter to the next pixel clock rising edge.

Top module: `lvds_tx21`

## Requirements
- R1: The word transmitted is the value of `din` at the falling edge of `pix_clk`; changes of `din` between that falling edge and the next rising edge have no effect on it.
- R2: Lane mapping: `din[6:0]` travels on `lane_o[0]`, `din[13:7]` on `lane_o[1]`, `din[20:14]` on `lane_o[2]`.
- R3: Within a pixel period a lane sends the highest-numbered bit of its group in slot 0, and so on down to the lowest-numbered bit in slot 6 (lane 0 sends bit 6 in slot 0 and bit 0 in slot 6).
- R4: Once aligned, `clk_lane_o` outputs over slots 0 to 6 of every period the pattern 1,1,0,0,0,1,1. Slot 0 begins at the bit clock rising edge that precedes the pixel clock rising edge.
- R5: A word captured at the falling edge in period n is transmitted in slots 0 to 6 of period n+1 (one pixel period latency).
- R6: While `shdn_n` is low, all four lanes are low from the first bit clock edge that samples it low, and all internal registers are cleared.
- R7: After `shdn_n` rises, all lanes stay low until the first pixel clock rising edge is seen. Data lanes stay low for the rest of that period, and no word captured before or during shutdown is ever sent.
- R8: Words follow one another with no gap. A receiver that frames on the clock-lane pattern recovers every word, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate, phase-aligned to `pix_clk` |
| pix_clk | input | 1 | Pixel clock; `din` is captured on its falling edge |
| shdn_n | input | 1 | Active-low shutdown and clear, synchronous to both clocks |
| din | input | 21 | Parallel data word |
| lane_o | output | 3 | Serial data lanes, one bit per slot |
| clk_lane_o | output | 1 | Framing clock lane, seven-slot pattern per pixel period |

## Verification
A slot counter that drifts or re-aligns on the wrong edge shows within one pixel period. The clock lane pattern rotates, and every data bit lands in a neighbouring slot, so a per-slot comparison fails in the first full period after lock. A wrong load strobe or lane mapping corrupts the next recovered word, which appears seven bit clocks after the load. A capture register that is not cleared shows as a stale word in the first period after shutdown release.

// File: rtl/lvds_tx_pkg.sv
package lvds_tx_pkg;
  localparam int unsigned TX_LANES = 3;
  localparam int unsigned TX_SLOTS = 7;
  // framing pattern, slot 0 in the MSB
  localparam logic [TX_SLOTS-1:0] TX_CLK_PATTERN = 7'b1100011;
  // sampler depth: a pixel rising edge is recognised at the edge opening this slot
  localparam int unsigned TX_RISE_SLOT = 2;
endpackage

// File: rtl/lvds_tx_capture.sv
module lvds_tx_capture #(
  parameter int unsigned W = 21
) (
  input  logic         pix_clk,
  input  logic         shdn_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cap_o
);
  // falling-edge capture, cleared while shut down
  always_ff @(negedge pix_clk) begin
    if (!shdn_n) cap_o <= '0;
    else         cap_o <= din;
  end
endmodule

// File: rtl/lvds_tx_slot_timer.sv
module lvds_tx_slot_timer #(
  parameter int unsigned SLOTS     = 7,
  parameter int unsigned RISE_SLOT = 2,
  localparam int unsigned SW       = $clog2(SLOTS)
) (
  input  logic          bit_clk,
  input  logic          shdn_n,
  input  logic          pix_clk,
  output logic [SW-1:0] slot_q,
  output logic [SW-1:0] slot_nxt,
  output logic          advance,
  output logic          load,
  output logic          locked
);
  logic pix_s1, pix_s2, rise;

  // pixel clock level sampled in the bit domain; two stages give RISE_SLOT
  always_ff @(posedge bit_clk) begin
    pix_s1 <= pix_clk;
    pix_s2 <= pix_s1;
  end

  assign rise = pix_s1 & ~pix_s2;

  always_comb begin
    if (rise)                          slot_nxt = SW'(RISE_SLOT);
    else if (slot_q == SW'(SLOTS - 1)) slot_nxt = '0;
    else                               slot_nxt = slot_q + 1'b1;
  end

  assign advance = rise | locked;
  assign load    = advance & (slot_nxt == '0);

  always_ff @(posedge bit_clk) begin
    if (!shdn_n) begin
      locked <= 1'b0;
      slot_q <= '0;
    end else if (advance) begin
      locked <= 1'b1;
      slot_q <= slot_nxt;
    end
  end
endmodule

// File: rtl/lvds_tx_lane.sv
module lvds_tx_lane #(
  parameter int unsigned LW = 7
) (
  input  logic          bit_clk,
  input  logic          shdn_n,
  input  logic          load,
  input  logic [LW-1:0] par_i,
  output logic          ser_o
);
  logic [LW-1:0] sreg;

  always_ff @(posedge bit_clk) begin
    if (!shdn_n)   sreg <= '0;
    else if (load) sreg <= par_i;
    else           sreg <= {sreg[LW-2:0], 1'b0};
  end

  assign ser_o = sreg[LW-1];
endmodule

// File: rtl/lvds_tx21.sv
module lvds_tx21
  import lvds_tx_pkg::*;
#(
  parameter int unsigned LANES = TX_LANES,
  parameter int unsigned SLOTS = TX_SLOTS,
  parameter logic [SLOTS-1:0] CLK_PATTERN = TX_CLK_PATTERN,
  localparam int unsigned W  = LANES * SLOTS,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic             bit_clk,
  input  logic             pix_clk,
  input  logic             shdn_n,
  input  logic [W-1:0]     din,
  output logic [LANES-1:0] lane_o,
  output logic             clk_lane_o
);
  logic [W-1:0]  cap_word;
  logic [SW-1:0] slot_q, slot_nxt;
  logic          advance, load, locked;

  lvds_tx_capture #(.W(W)) u_cap (
    .pix_clk (pix_clk),
    .shdn_n  (shdn_n),
    .din     (din),
    .cap_o   (cap_word)
  );

  lvds_tx_slot_timer #(.SLOTS(SLOTS), .RISE_SLOT(TX_RISE_SLOT)) u_timer (
    .bit_clk  (bit_clk),
    .shdn_n   (shdn_n),
    .pix_clk  (pix_clk),
    .slot_q   (slot_q),
    .slot_nxt (slot_nxt),
    .advance  (advance),
    .load     (load),
    .locked   (locked)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lvds_tx_lane #(.LW(SLOTS)) u_lane (
      .bit_clk (bit_clk),
      .shdn_n  (shdn_n),
      .load    (load),
      .par_i   (cap_word[g*SLOTS +: SLOTS]),
      .ser_o   (lane_o[g])
    );
  end

  // framing lane, registered, follows the slot about to open
  always_ff @(posedge bit_clk) begin
    if (!shdn_n || !advance) clk_lane_o <= 1'b0;
    else                     clk_lane_o <= CLK_PATTERN[SLOTS - 1 - int'(slot_nxt)];
  end
endmodule

// File: rtl/lvds_tx21_chk.sv
module lvds_tx21_chk #(
  parameter int unsigned LANES = 3,
  parameter int unsigned SLOTS = 7,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input logic             bit_clk,
  input logic             shdn_n,
  input logic [LANES-1:0] lane_o,
  input logic             clk_lane_o,
  input logic             locked,
  input logic [SW-1:0]    slot_q,
  input logic             load
);
  logic [SW-1:0] since_load;
  logic          seen_load;

  always_ff @(posedge bit_clk) begin
    if (!shdn_n) begin
      since_load <= '0;
      seen_load  <= 1'b0;
    end else if (load) begin
      since_load <= '0;
      seen_load  <= 1'b1;
    end else if (since_load != SW'(SLOTS - 1)) begin
      since_load <= since_load + 1'b1;
    end
  end

  p_shutdown_quiet_r6: assert property (@(posedge bit_clk)
    !shdn_n |=> (lane_o == '0 && !clk_lane_o));

  p_unlocked_quiet_r7: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    !locked |-> (lane_o == '0 && !clk_lane_o));

  p_clk_pattern_r4: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    locked |-> (clk_lane_o == CLK_PATTERN[SLOTS - 1 - int'(slot_q)]));

  p_load_spacing_r8: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    (load && seen_load) |-> (since_load == SW'(SLOTS - 1)));

  p_load_opens_slot0_r5: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    load |=> (slot_q == '0 && locked));
endmodule

bind lvds_tx21 lvds_tx21_chk #(
  .LANES(LANES), .SLOTS(SLOTS), .CLK_PATTERN(CLK_PATTERN)
) u_chk (
  .bit_clk    (bit_clk),
  .shdn_n     (shdn_n),
  .lane_o     (lane_o),
  .clk_lane_o (clk_lane_o),
  .locked     (locked),
  .slot_q     (slot_q),
  .load       (load)
);

// File: tb/tb_lvds_tx21.sv
module tb_lvds_tx21;
  localparam int unsigned SLOTS = 7;
  localparam int unsigned LANES = 3;
  localparam int unsigned W     = 21;
  localparam logic [6:0]  PAT   = 7'b1100011;

  logic bit_clk = 1'b0, pix_clk = 1'b0, shdn_n = 1'b0;
  logic [W-1:0] din = '0;
  logic [LANES-1:0] lane_o;
  logic clk_lane_o;

  int errors = 0, checks = 0, frames = 0;
  int pcount = 0, bslot = 0, rises = 0;
  logic [W-1:0] hist_w [8];
  bit           hist_v [8];
  logic [6:0]   clk_hist = '0;
  logic [6:0]   lane_hist [LANES];

  lvds_tx21 dut (
    .bit_clk(bit_clk), .pix_clk(pix_clk), .shdn_n(shdn_n),
    .din(din), .lane_o(lane_o), .clk_lane_o(clk_lane_o)
  );

  // 125 MHz bit clock: rising edges at 4 + 8k
  always #4 bit_clk = ~bit_clk;
  // pixel clock: rises 1 ns after the bit edge opening slot 0, high 4 slots
  initial begin
    #5;
    forever begin
      pix_clk = 1'b1; #32;
      pix_clk = 1'b0; #24;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] next_word(input int n);
    case (n % 16)
      0: return '0;
      1: return '1;
      2: return 21'h155555;
      3: return 21'h0AAAAA;
      4: return W'(1) << ((n / 16) % W);
      default: return W'($urandom);
    endcase
  endfunction

  always @(posedge bit_clk) bslot = bslot + 1;
  always @(posedge pix_clk) begin
    bslot  = 0;
    pcount = pcount + 1;
    rises  = shdn_n ? rises + 1 : 0;
  end

  // word stimulus: valid word before the falling edge, junk after it (R1)
  int wn = 0;
  always @(posedge pix_clk) begin
    #2 din = next_word(wn);
    wn++;
  end
  always @(negedge pix_clk) begin
    #1;
    hist_w[pcount & 7] = din;
    hist_v[pcount & 7] = shdn_n;
    #2 din = W'($urandom);
  end

  // per-slot checks and framing receiver, mid-slot
  always @(negedge bit_clk) begin
    logic [W-1:0] exp_w;
    int idx;
    clk_hist = {clk_hist[5:0], clk_lane_o};
    for (int i = 0; i < LANES; i++) lane_hist[i] = {lane_hist[i][5:0], lane_o[i]};
    if (!shdn_n) begin
      chk(lane_o == '0 && clk_lane_o == 1'b0, "R6 lanes low in shutdown", {lane_o, clk_lane_o}, 0);
    end else if (rises == 0) begin
      chk(lane_o == '0 && clk_lane_o == 1'b0, "R7 lanes low before first rise", {lane_o, clk_lane_o}, 0);
    end else begin
      idx   = (pcount - 1) & 7;
      exp_w = hist_v[idx] ? hist_w[idx] : '0;
      for (int i = 0; i < LANES; i++)
        chk(lane_o[i] == exp_w[i*SLOTS + SLOTS - 1 - bslot],
            "R2 R3 R5 R7 lane bit", 32'(lane_o[i]), 32'(exp_w[i*SLOTS + SLOTS - 1 - bslot]));
      if (rises >= 2) begin
        chk(clk_lane_o == PAT[SLOTS - 1 - bslot], "R4 clock lane slot", 32'(clk_lane_o), 32'(PAT[SLOTS - 1 - bslot]));
        if (bslot == SLOTS - 1) begin
          chk(clk_hist == PAT, "R8 frame marker", 32'(clk_hist), 32'(PAT));
          if (clk_hist == PAT) begin
            frames++;
            chk({lane_hist[2], lane_hist[1], lane_hist[0]} == exp_w, "R8 R1 recovered word",
                32'({lane_hist[2], lane_hist[1], lane_hist[0]}), 32'(exp_w));
          end
        end
      end
    end
  end

  task automatic release_sd();
    @(negedge pix_clk);
    @(negedge bit_clk);
    #1 shdn_n = 1'b1;
  endtask

  task automatic shutdown_at(input int slot_mid);
    @(posedge pix_clk);
    repeat (slot_mid + 1) @(negedge bit_clk);
    #1 shdn_n = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1D5EED));
    repeat (20) @(negedge bit_clk);
    release_sd();
    repeat (150) @(posedge pix_clk);
    shutdown_at(2);              // mid-word shutdown
    repeat (25) @(negedge bit_clk);
    release_sd();
    repeat (100) @(posedge pix_clk);
    shutdown_at(6);              // shutdown in the last slot
    repeat (16) @(negedge bit_clk);
    release_sd();
    repeat (60) @(posedge pix_clk);
    chk(frames > 250, "R8 frame count", 32'(frames), 251);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", pcount);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule